// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands (1 sign bit, 8 exponent bits biased by 127, 23 fraction bits with an implied leading one) and returns a packed 32-bit result. A one-bit select turns the operation into a subtraction by inverting the sign of the second operand before anything else happens. The result is rounded to nearest, with ties going to the even neighbour. Two flags report exponent overflow and underflow.

Inside, the operand with the smaller exponent is shifted right to line up with the other one. Three extra bits are kept below the last fraction bit: guard, round, and a sticky bit that collects everything shifted further out. The aligned significands are then added, or subtracted by adding the two's complement. A negative difference is turned back into sign and magnitude. The sum is normalized right by one on a carry, or left by its leading-zero count. It is then rounded, and normalized again if rounding carries out.

Operands with a zero exponent field are treated as zeros. Infinities and NaNs pass through simple rules. One request is accepted per clock, and its result appears on the next clock with a valid strobe.

Top module: `fp_addsub_unit`

## Requirements
- R1: After reset, out_valid, result, ovf and unf are all 0. Every cycle with in_valid high gives out_valid high exactly one clock later. A cycle without in_valid gives out_valid low one clock later.
- R2: When both operands have the same sign, the result is their correctly rounded sum (for example 1.0 + 2.0 = 0x40400000).
- R3: With sub_sel = 1 the result is op_a − op_b, computed as op_a + (−op_b) (for example 3.0 − 1.0 = 0x40000000).
- R4: A difference that comes out negative in two's complement is returned as a magnitude with the sign bit (bit 31) set (1.0 − 1.5 = 0xBF000000).
- R5: A significand sum of 2 or more is shifted right by one and its exponent is raised by one (1.5 + 1.5 = 0x40400000).
- R6: After cancellation, the result is shifted left by its leading-zero count and the exponent is lowered by the same count (0x3F800001 − 0x3F800000 = 0x34000000).
- R7: Rounding is to nearest, with ties to even. The sticky bit is the OR of all bits shifted out below the round position, so an exact half rounds to an even last bit, and anything above half rounds up.
- R8: When rounding carries out of the significand, the result is renormalized with the exponent raised by one (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R9: A final exponent above 254 sets ovf and returns infinity with the result's sign (exponent field 0xFF, fraction 0). This includes overflow caused by rounding.
- R10: A final exponent below 1 sets unf and returns a zero with the result's sign.
- R11: Any operand with a zero exponent field counts as zero of its own sign, whatever its fraction. The sum of two zeros of the same sign is that signed zero, with both flags clear.
- R12: A NaN operand, or the sum of two infinities with opposite effective signs, returns the quiet NaN 0x7FC00000. Otherwise an infinity operand returns that infinity with its effective sign. Special results clear both flags.
- R13: Subtracting equal nonzero magnitudes gives +0 (0x00000000) with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are presented this cycle |
| op_a | input | 32 | First operand, packed single precision |
| op_b | input | 32 | Second operand, packed single precision |
| sub_sel | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| out_valid | output | 1 | Result and flags belong to the request of the previous cycle |
| result | output | 32 | Packed single-precision result |
| ovf | output | 1 | Exponent overflow, result forced to signed infinity |
| unf | output | 1 | Exponent underflow, result forced to signed zero |

## Verification
Two steps that can land in the same evaluation are checked together on purpose.

The first pair is rounding and overflow. Adding half an ulp to the largest finite value creates a tie whose last bit is odd. Rounding then carries out, and the exponent rises from 254 to 255. The bench expects infinity with ovf set, not the largest finite value.

The second pair is sign conversion and left normalization. In 1.0 − 1.5 the exponents are equal, so the difference is negative and must also be shifted left. The bench judges both the sign bit and the one-place normalization in the same packed result.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NORM = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } fp_class_e;

   // zero-exponent encodings (denormals included) are folded into CLS_ZERO
   function automatic fp_class_e classify(input logic exp_ones,
                                          input logic exp_zero,
                                          input logic frac_zero);
      if (exp_ones)      return frac_zero ? CLS_INF : CLS_NAN;
      else if (exp_zero) return CLS_ZERO;
      else               return CLS_NORM;
   endfunction

endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]   op_a,
   input  logic [EXP_W+FRAC_W:0]   op_b,
   input  logic                    sub_sel,
   output fpa_pkg::fp_class_e      cls_a,
   output fpa_pkg::fp_class_e      cls_b,
   output logic                    sgn_a,
   output logic                    sgn_b_eff,
   output logic                    eff_sub,
   output logic                    sign_big,
   output logic [EXP_W-1:0]        exp_big,
   output logic [FRAC_W+3:0]       big_ext,
   output logic [FRAC_W+3:0]       small_ext
);
   localparam int P  = FRAC_W + 1;
   localparam int W  = P + 3;
   localparam int CW = $clog2(W + 1);
   localparam logic [W-1:0] ONE = W'(1);

   logic [EXP_W-1:0]  ea, eb, exp_small, diff;
   logic [FRAC_W-1:0] fa, fb;
   logic [P-1:0]      sig_a, sig_b, big_sig, small_sig;
   logic [CW-1:0]     sh;
   logic [W-1:0]      ext, shifted, lost_mask;
   logic              swap, lost;

   assign ea = op_a[EXP_W+FRAC_W-1:FRAC_W];
   assign eb = op_b[EXP_W+FRAC_W-1:FRAC_W];
   assign fa = op_a[FRAC_W-1:0];
   assign fb = op_b[FRAC_W-1:0];

   assign sgn_a     = op_a[EXP_W+FRAC_W];
   assign sgn_b_eff = op_b[EXP_W+FRAC_W] ^ sub_sel;
   assign eff_sub   = sgn_a ^ sgn_b_eff;

   assign cls_a = fpa_pkg::classify(&ea, ~|ea, ~|fa);
   assign cls_b = fpa_pkg::classify(&eb, ~|eb, ~|fb);

   // flush-to-zero: a zero exponent field drops the fraction entirely
   assign sig_a = (ea == '0) ? '0 : {1'b1, fa};
   assign sig_b = (eb == '0) ? '0 : {1'b1, fb};

   assign swap      = (eb > ea);
   assign big_sig   = swap ? sig_b : sig_a;
   assign small_sig = swap ? sig_a : sig_b;
   assign exp_big   = swap ? eb : ea;
   assign exp_small = swap ? ea : eb;
   assign sign_big  = swap ? sgn_b_eff : sgn_a;
   assign diff      = exp_big - exp_small;

   always_comb begin
      if (32'(diff) > W) sh = CW'(W);
      else               sh = CW'(diff);
   end

   assign ext       = {small_sig, 3'b000};
   assign shifted   = ext >> sh;
   assign lost_mask = (ONE << sh) - ONE;
   assign lost      = |(ext & lost_mask);
   assign small_ext = {shifted[W-1:1], shifted[0] | lost};
   assign big_ext   = {big_sig, 3'b000};

   // R7: the aligned operand never exceeds the unshifted one when exponents differ
   always_comb begin
      if (diff != '0)
         a_r7_align_shrinks: assert (small_ext < big_ext || big_sig == '0);
   end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
   parameter int IN_W = 27,
   localparam int CW  = $clog2(IN_W + 1)
) (
   input  logic [IN_W-1:0] vec_i,
   output logic [CW-1:0]   zeros_o
);
   always_comb begin
      zeros_o = CW'(IN_W);
      for (int i = 0; i < IN_W; i++) begin
         if (vec_i[i]) zeros_o = CW'(IN_W - 1 - i);
      end
   end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W+4:0]         mag_i,
   input  logic signed [EXP_W+1:0]   exp_i,
   input  logic                      sign_i,
   input  logic                      zero_sign_i,
   output logic [EXP_W+FRAC_W:0]     result_o,
   output logic                      ovf_o,
   output logic                      unf_o
);
   localparam int P  = FRAC_W + 1;
   localparam int W  = P + 3;
   localparam int M  = W + 1;
   localparam int EW = EXP_W + 2;
   localparam int CW = $clog2(W + 1);
   localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 2);
   localparam logic signed [EW-1:0] EMIN = EW'(1);

   logic [CW-1:0]          lz;
   logic [W-1:0]           norm;
   logic signed [EW-1:0]   exp_n, exp_f;
   logic [P:0]             rnd;
   logic [P-1:0]           sig;
   logic                   up, zero;

   fpa_lzc #(.IN_W(W)) u_lzc (
      .vec_i  (mag_i[W-1:0]),
      .zeros_o(lz)
   );

   always_comb begin
      if (mag_i[M-1]) begin
         norm    = mag_i[M-1:1];
         norm[0] = mag_i[1] | mag_i[0];
         exp_n   = exp_i + EW'(1);
      end else begin
         norm  = mag_i[W-1:0] << lz;
         exp_n = exp_i - EW'(lz);
      end
      up  = norm[2] & (norm[1] | norm[0] | norm[3]);
      rnd = {1'b0, norm[W-1:3]} + (P+1)'(up);
      if (rnd[P]) begin
         sig   = rnd[P:1];
         exp_f = exp_n + EW'(1);
      end else begin
         sig   = rnd[P-1:0];
         exp_f = exp_n;
      end
   end

   assign zero = (mag_i == '0);

   always_comb begin
      ovf_o = 1'b0;
      unf_o = 1'b0;
      if (zero) begin
         result_o = {zero_sign_i, {(EXP_W+FRAC_W){1'b0}}};
      end else if (exp_f > EMAX) begin
         ovf_o    = 1'b1;
         result_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (exp_f < EMIN) begin
         unf_o    = 1'b1;
         result_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
      end else begin
         result_o = {sign_i, exp_f[EXP_W-1:0], sig[FRAC_W-1:0]};
      end
   end

   // R6: leading-zero count and shifter together put a one in the hidden position
   always_comb begin
      if (!mag_i[M-1] && !zero)
         a_r6_lead_one: assert (norm[W-1]);
   end
endmodule

// File: rtl/fp_addsub_unit.sv
module fp_addsub_unit #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [EXP_W+FRAC_W:0]   op_a,
   input  logic [EXP_W+FRAC_W:0]   op_b,
   input  logic                    sub_sel,
   output logic                    out_valid,
   output logic [EXP_W+FRAC_W:0]   result,
   output logic                    ovf,
   output logic                    unf
);
   import fpa_pkg::*;

   localparam int DW = 1 + EXP_W + FRAC_W;
   localparam int P  = FRAC_W + 1;
   localparam int W  = P + 3;
   localparam int M  = W + 1;
   localparam int EW = EXP_W + 2;
   localparam logic [DW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_cfg
      $error("fp_addsub_unit: EXP_W must be >= 3 and FRAC_W >= 2");
   end

   fp_class_e            cls_a, cls_b;
   logic                 sgn_a, sgn_b_eff, eff_sub, sign_big, neg;
   logic [EXP_W-1:0]     exp_big;
   logic [W-1:0]         big_ext, small_ext;
   logic [W+1:0]         sum;
   logic [M-1:0]         mag;
   logic signed [EW-1:0] exp_start;
   logic [DW-1:0]        arith_res, res_d;
   logic                 arith_ovf, arith_unf, ovf_d, unf_d, is_nan;

   fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .op_a     (op_a),
      .op_b     (op_b),
      .sub_sel  (sub_sel),
      .cls_a    (cls_a),
      .cls_b    (cls_b),
      .sgn_a    (sgn_a),
      .sgn_b_eff(sgn_b_eff),
      .eff_sub  (eff_sub),
      .sign_big (sign_big),
      .exp_big  (exp_big),
      .big_ext  (big_ext),
      .small_ext(small_ext)
   );

   // signed significand add; subtraction adds the two's complement
   always_comb begin
      if (eff_sub) sum = {2'b00, big_ext} + ~{2'b00, small_ext} + (W+2)'(1);
      else         sum = {2'b00, big_ext} + {2'b00, small_ext};
      neg = sum[W+1];
      mag = neg ? M'(~sum + (W+2)'(1)) : M'(sum);
   end

   assign exp_start = {2'b00, exp_big};

   fpa_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
      .mag_i      (mag),
      .exp_i      (exp_start),
      .sign_i     (sign_big ^ neg),
      .zero_sign_i(sign_big & ~eff_sub),
      .result_o   (arith_res),
      .ovf_o      (arith_ovf),
      .unf_o      (arith_unf)
   );

   assign is_nan = (cls_a == CLS_NAN) || (cls_b == CLS_NAN) ||
                   (cls_a == CLS_INF && cls_b == CLS_INF && eff_sub);

   always_comb begin
      res_d = arith_res;
      ovf_d = arith_ovf;
      unf_d = arith_unf;
      if (is_nan || cls_a == CLS_INF || cls_b == CLS_INF) begin
         ovf_d = 1'b0;
         unf_d = 1'b0;
         if (is_nan)                res_d = QNAN;
         else if (cls_a == CLS_INF) res_d = {sgn_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         else                       res_d = {sgn_b_eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= res_d;
               ovf    <= ovf_d;
               unf    <= unf_d;
            end
         end
      end

      a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r9_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && ovf) |-> (result[DW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
      a_r10_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && unf) |-> (result[DW-2:0] == '0));
      a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
         !(ovf && unf));
      a_r12_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (&op_a[DW-2:FRAC_W]) && (|op_a[FRAC_W-1:0])) |=> (result == QNAN));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_d;
      assign ovf       = ovf_d;
      assign unf       = unf_d;
   end
endmodule

// File: tb/sim_fp_addsub_unit.sv
module sim_fp_addsub_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        sub_sel = 1'b0;
   logic        out_valid, ovf, unf;
   logic [31:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fp_addsub_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .sub_sel(sub_sel), .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
   );

   task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                  req, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
      end
   endtask

   // drive one request at a negedge, sample the registered answer one edge later
   task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic s, input logic [31:0] er, input logic eo, input logic eu);
      @(negedge clk);
      op_a = a; op_b = b; sub_sel = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, {result, ovf, unf}, {er, eo, eu});
   endtask

   task automatic t_reset;
      check("R1 reset", {result, ovf, unf}, 34'd0);
      check("R1 reset valid", {32'd0, 1'b0, out_valid}, 34'd0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      op_a = 32'h3F800000; op_b = 32'h3F800000; sub_sel = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 valid one clock later", {32'd0, 1'b0, out_valid}, {32'd0, 1'b0, 1'b1});
      @(negedge clk);
      check("R1 valid drops", {32'd0, 1'b0, out_valid}, 34'd0);
   endtask

   task automatic t_same_sign;
      run("R2 1+2", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0);
      run("R2 -1+-2", 32'hBF800000, 32'hC0000000, 1'b0, 32'hC0400000, 1'b0, 1'b0);
   endtask

   task automatic t_sub_op;
      run("R3 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0);
      run("R3 1-(-2)", 32'h3F800000, 32'hC0000000, 1'b1, 32'h40400000, 1'b0, 1'b0);
   endtask

   task automatic t_neg_diff;
      // negative two's complement difference together with a left shift by one
      run("R4 1-1.5", 32'h3F800000, 32'h3FC00000, 1'b1, 32'hBF000000, 1'b0, 1'b0);
   endtask

   task automatic t_carry;
      run("R5 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0);
   endtask

   task automatic t_cancel;
      run("R6 cancel", 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 1'b0, 1'b0);
   endtask

   task automatic t_round;
      run("R7 tie even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
      run("R7 tie odd up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0);
      run("R7 sticky up", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0);
   endtask

   task automatic t_round_carry;
      run("R8 round carry", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
   endtask

   task automatic t_overflow;
      run("R9 max+max", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0);
      run("R9 neg max", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0);
      run("R9 rounding overflow", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0);
   endtask

   task automatic t_underflow;
      run("R10 pos tiny", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1);
      run("R10 neg tiny", 32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 1'b0, 1'b1);
   endtask

   task automatic t_denorm;
      run("R11 denorm pos", 32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 1'b0, 1'b0);
      run("R11 denorm neg", 32'h80400000, 32'h80400000, 1'b0, 32'h80000000, 1'b0, 1'b0);
      run("R11 denorm plus one", 32'h007FFFFF, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
   endtask

   task automatic t_special;
      run("R12 qnan in", 32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0);
      run("R12 snan in b", 32'h3F800000, 32'h7F800001, 1'b0, 32'h7FC00000, 1'b0, 1'b0);
      run("R12 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b0);
      run("R12 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0);
      run("R12 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0);
   endtask

   task automatic t_exact_zero;
      run("R13 2.5-2.5", 32'h40200000, 32'h40200000, 1'b1, 32'h00000000, 1'b0, 1'b0);
      run("R13 -1+1", 32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_latency();
      t_same_sign();
      t_sub_op();
      t_neg_diff();
      t_carry();
      t_cancel();
      t_round();
      t_round_carry();
      t_overflow();
      t_underflow();
      t_denorm();
      t_special();
      t_exact_zero();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule